// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the digital front end of an eight-input, twelve-bit sampling converter. Software reaches it through two word-wide registers on a simple bus: a setup word and a result word. The setup word picks which inputs take part, how far the bus clock is divided to make the conversion clock, and how a conversion is launched. A conversion can start on a bus command, on a chosen edge of one of six external event lines, or run back to back in a repeating scan. The analog converter is outside the block. The controller gives it a channel index and a one-cycle start pulse, counts a fixed number of conversion-clock pulses, and then takes in the twelve-bit sample.

The result word holds the latest sample, the input it came from, a completion flag, and a flag that reports lost results during a scan. Reading the result word clears both flags. Writing the setup word also clears them. A setup write that lands while a conversion is running abandons that conversion and starts over.

Top module: `adc_ctl_top`

## Requirements
- R1: After reset both registers read zero, `cnv_start` is low and no conversion runs.
- R2: The setup word (address 0) reads back the written value masked with 0x0F21FFFF. All other bits read zero. Its fields are: channel mask in bits 7:0, divisor in bits 15:8, scan enable in bit 16, power enable in bit 21, launch code in bits 26:24 and edge polarity in bit 27.
- R3: A single conversion converts the lowest set bit of the channel mask. An all-zero mask acts as mask 0x01 (channel 0).
- R4: While power is enabled, `cclk_en` pulses once in every divisor+1 bus cycles.
- R5: The completion flag (result word bit 31) is set exactly 65×(divisor+1) cycles after the edge that launched the conversion. At that point the result word holds the sample in bits 15:4 and the channel number in bits 26:24.
- R6: With scan off, launch code 0 starts nothing and launch code 1 starts one conversion on the setup write.
- R7: Launch codes 2..7 arm event line `ext_trig[code-2]`. Edge polarity 1 selects rising edges and 0 selects falling edges. The other polarity, other lines, and any edge during a running conversion are ignored.
- R8: With scan on, the selected channels are converted from lowest to highest and then wrap around. A setup write that clears scan ends the repetition: after that write, at most the one conversion it launches runs.
- R9: With power off, no `cnv_start` pulse occurs, no result completes and `cclk_en` stays low, whatever the launch code.
- R10: A read of the result word (address 1) clears the completion flag. A setup write also clears it. A setup write with power on during a conversion restarts it, and completion then follows R5 counted from that write.
- R11: The overrun flag (bit 27) is set when a scan conversion completes while the completion flag is still set. A read clears it. If a read and a completion fall in the same cycle, the completion flag ends set and the overrun flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags on the result word) |
| bus_addr | input | 1 | 0 = setup word, 1 = result word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ext_trig | input | 6 | Asynchronous event lines for launching conversions |
| cclk_en | output | 1 | Divided conversion-clock pulse |
| cnv_chan | output | 3 | Channel index sent to the converter |
| cnv_start | output | 1 | One-cycle conversion launch pulse |
| cnv_data | input | 12 | Sample returned by the converter |

## Verification
The cycle in which a scan conversion completes can coincide with a bus read of the result word. The two actions then compete for the completion and overrun flags. The bench launches a scan, counts cycles from the launching write to the second completion, and places the read strobe exactly on that edge. It then expects the completion flag set and the overrun flag clear. One conversion later, with no read, it expects the overrun flag to be raised.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
   // setup word field positions
   localparam int SEL_LSB   = 0;
   localparam int DIV_LSB   = 8;
   localparam int SCAN_BIT  = 16;
   localparam int PWR_BIT   = 21;
   localparam int LAUNCH_LSB = 24;
   localparam int POL_BIT   = 27;
   localparam logic [31:0] SETUP_WMASK = 32'h0F21_FFFF;
   // result word field positions
   localparam int RES_LSB   = 4;
   localparam int CHN_LSB   = 24;
   localparam int OVR_BIT   = 27;
   localparam int DONE_BIT  = 31;
   // launch codes
   localparam logic [2:0] LAUNCH_NONE = 3'd0;
   localparam logic [2:0] LAUNCH_NOW  = 3'd1;
   localparam logic [2:0] LAUNCH_EXT0 = 3'd2;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || !run)  cnt_q <= '0;
      else if (cnt_q >= div)     cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int NTRIG = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NTRIG-1:0] trig_in,
   output logic [NTRIG-1:0] rise,
   output logic [NTRIG-1:0] fall
);
   logic [NTRIG-1:0] meta_q, sync_q, last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         last_q <= '0;
      end else begin
         meta_q <= trig_in;
         sync_q <= meta_q;
         last_q <= sync_q;
      end
   end

   assign rise = sync_q & ~last_q;
   assign fall = ~sync_q & last_q;
endmodule

// File: rtl/adc_chan_sel.sv
module adc_chan_sel #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input  logic [NCH-1:0]  mask,
   input  logic [CH_W-1:0] cur,
   output logic [CH_W-1:0] first,
   output logic [CH_W-1:0] nxt
);
   logic got_first, got_next;

   always_comb begin
      first     = '0;
      got_first = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (!got_first && mask[i]) begin
            first     = CH_W'(i);
            got_first = 1'b1;
         end
      end
      nxt      = first;
      got_next = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (!got_next && mask[i] && (i > int'(cur))) begin
            nxt      = CH_W'(i);
            got_next = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top
   import adc_ctl_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int RES_W     = 12,
   parameter int NTRIG     = 6,
   parameter int CONV_CLKS = 65,
   parameter int DIV_W     = 8,
   localparam int CH_W     = $clog2(NCH),
   localparam int CNT_W    = $clog2(CONV_CLKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [NTRIG-1:0] ext_trig,
   output logic             cclk_en,
   output logic [CH_W-1:0]  cnv_chan,
   output logic             cnv_start,
   input  logic [RES_W-1:0] cnv_data
);
   generate
      if (NCH < 2 || NCH > 8)       begin : g_bad_nch   $error("NCH must be 2..8");      end
      if (NTRIG < 1 || NTRIG > 6)   begin : g_bad_trig  $error("NTRIG must be 1..6");    end
      if (RES_W < 1 || RES_W > 12)  begin : g_bad_res   $error("RES_W must be 1..12");   end
      if (DIV_W < 1 || DIV_W > 8)   begin : g_bad_div   $error("DIV_W must be 1..8");    end
      if (CONV_CLKS < 2)            begin : g_bad_conv  $error("CONV_CLKS must be >= 2"); end
   endgenerate

   // registers
   logic [31:0]      setup_q;
   logic             busy_q, start_q, done_q, ovr_q;
   logic [CNT_W-1:0] ccnt_q;
   logic [CH_W-1:0]  chan_q, res_chan_q;
   logic [RES_W-1:0] result_q;

   // strobes
   logic wr_setup, rd_result;
   assign wr_setup  = bus_wr && !bus_addr;
   assign rd_result = bus_rd && bus_addr;

   logic [31:0] setup_new;
   assign setup_new = bus_wdata & SETUP_WMASK;

   // decoded fields
   logic [NCH-1:0]   mask_raw, mask_new_raw, eff_mask, pick_mask;
   logic [DIV_W-1:0] div;
   logic             scan_on, pwr_on, pol_rise;
   logic [2:0]       launch;
   assign mask_raw     = setup_q[SEL_LSB +: NCH];
   assign mask_new_raw = setup_new[SEL_LSB +: NCH];
   assign eff_mask     = (mask_raw == '0) ? NCH'(1) : mask_raw;
   assign pick_mask    = wr_setup ? ((mask_new_raw == '0) ? NCH'(1) : mask_new_raw) : eff_mask;
   assign div          = setup_q[DIV_LSB +: DIV_W];
   assign scan_on      = setup_q[SCAN_BIT];
   assign pwr_on       = setup_q[PWR_BIT];
   assign launch       = setup_q[LAUNCH_LSB +: 3];
   assign pol_rise     = setup_q[POL_BIT];

   // sub blocks
   logic tick, go;
   logic [CH_W-1:0] first_ch, next_ch, go_chan;
   logic [NTRIG-1:0] rise, fall;

   adc_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
      .clk(clk), .rst_n(rst_n), .run(pwr_on), .restart(go), .div(div), .tick(tick)
   );

   adc_trig_edge #(.NTRIG(NTRIG)) trig_i (
      .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .rise(rise), .fall(fall)
   );

   adc_chan_sel #(.NCH(NCH), .CH_W(CH_W)) pick_i (
      .mask(pick_mask), .cur(chan_q), .first(first_ch), .nxt(next_ch)
   );

   // trigger selection
   logic [7:0] rise_pad, fall_pad;
   logic [2:0] trig_idx;
   logic       trig_hit, conv_end;
   assign rise_pad = 8'(rise);
   assign fall_pad = 8'(fall);
   assign trig_idx = launch - LAUNCH_EXT0;
   assign trig_hit = !busy_q && pwr_on && !scan_on && (launch >= LAUNCH_EXT0) &&
                     (pol_rise ? rise_pad[trig_idx] : fall_pad[trig_idx]);
   assign conv_end = busy_q && tick && (ccnt_q == CNT_W'(CONV_CLKS - 1));

   // launch decision
   always_comb begin
      go      = 1'b0;
      go_chan = first_ch;
      if (wr_setup) begin
         go = setup_new[PWR_BIT] &&
              (busy_q || setup_new[SCAN_BIT] || setup_new[LAUNCH_LSB +: 3] == LAUNCH_NOW);
      end else if (conv_end) begin
         go      = scan_on && pwr_on;
         go_chan = next_ch;
      end else if (trig_hit) begin
         go = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q    <= '0;
         busy_q     <= 1'b0;
         start_q    <= 1'b0;
         ccnt_q     <= '0;
         chan_q     <= '0;
         res_chan_q <= '0;
         result_q   <= '0;
         done_q     <= 1'b0;
         ovr_q      <= 1'b0;
      end else begin
         start_q <= go;
         if (wr_setup) setup_q <= setup_new;

         if (go)                       busy_q <= 1'b1;
         else if (wr_setup || conv_end) busy_q <= 1'b0;

         if (go)                  ccnt_q <= '0;
         else if (busy_q && tick) ccnt_q <= ccnt_q + 1'b1;

         if (go) chan_q <= go_chan;

         if (wr_setup) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
         end else if (conv_end) begin
            result_q   <= cnv_data;
            res_chan_q <= chan_q;
            done_q     <= 1'b1;
            ovr_q      <= scan_on && done_q && !rd_result;
         end else if (rd_result) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
      end
   end

   logic [31:0] result_word;
   always_comb begin
      result_word                 = '0;
      result_word[DONE_BIT]       = done_q;
      result_word[OVR_BIT]        = ovr_q;
      result_word[CHN_LSB +: 3]   = 3'(res_chan_q);
      result_word[RES_LSB +: 12]  = 12'(result_q);
   end

   assign bus_rdata = bus_addr ? result_word : setup_q;
   assign cclk_en   = tick;
   assign cnv_chan  = chan_q;
   assign cnv_start = start_q;
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
   parameter int NCH  = 8,
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic            bus_addr,
   input logic [31:0]     setup_q,
   input logic [NCH-1:0]  eff_mask,
   input logic            busy_q,
   input logic            done_q,
   input logic            ovr_q,
   input logic            cnv_start,
   input logic [CH_W-1:0] cnv_chan
);
   assert_start_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> setup_q[21]);

   assert_chan_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> eff_mask[cnv_chan]);

   assert_done_after_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(busy_q));

   assert_write_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr) |=> !done_q);

   assert_ovr_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> done_q);
endmodule

bind adc_ctl_top adc_ctl_chk #(.NCH(NCH), .CH_W(CH_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .setup_q(setup_q), .eff_mask(eff_mask), .busy_q(busy_q), .done_q(done_q),
   .ovr_q(ovr_q), .cnv_start(cnv_start), .cnv_chan(cnv_chan)
);

// File: tb/adc_ctl_top_tb_top.sv
`timescale 1ns/1ps
module adc_ctl_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b1;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  ext_trig = '0;
   logic        cclk_en, cnv_start;
   logic [2:0]  cnv_chan;
   logic [11:0] cnv_data;
   logic [11:0] analog [8];

   int checks = 0, errors = 0;
   int nstarts = 0, ncclk = 0, nlog = 0;
   int chan_log [32];

   always #2 clk = ~clk;

   assign cnv_data = analog[cnv_chan];

   adc_ctl_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
      .cclk_en(cclk_en), .cnv_chan(cnv_chan), .cnv_start(cnv_start), .cnv_data(cnv_data)
   );

   always @(negedge clk) begin
      if (cnv_start) begin
         nstarts++;
         if (nlog < 32) chan_log[nlog] = int'(cnv_chan);
         nlog++;
      end
      if (cclk_en) ncclk++;
   end

   localparam logic [31:0] PWR  = 32'h0020_0000;
   localparam logic [31:0] SCAN = 32'h0001_0000;

   function automatic logic [31:0] launch_f(input int code);
      return 32'(code) << 24;
   endfunction
   function automatic logic [31:0] div_f(input int d);
      return 32'(d) << 8;
   endfunction
   function automatic logic [31:0] exp_word(input bit d, input bit o, input int ch, input logic [11:0] r);
      return {d, 3'b000, o, 3'(ch), 8'h00, r, 4'h0};
   endfunction
   function automatic int low_chan(input logic [7:0] m);
      for (int i = 0; i < 8; i++) if (m[i]) return i;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_setup(input logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic rd_reg(input bit a, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!bus_rdata[31] && n < 20000);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] v;
      int n, ch, dv, s;
      logic [7:0] m;
      s = $urandom(32'h00C0FFEE);
      for (int i = 0; i < 8; i++) analog[i] = 12'($urandom);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(bus_rdata == 32'h0, "R1 result word", bus_rdata, 0);
      bus_addr = 1'b0; #1;
      chk(bus_rdata == 32'h0, "R1 setup word", bus_rdata, 0);
      bus_addr = 1'b1;
      repeat (20) @(posedge clk);
      chk(nstarts == 0, "R1 no start", nstarts, 0);

      // R2 readback masking
      wr_setup(32'hFFFF_FFFF);
      rd_reg(1'b0, v);
      chk(v == 32'h0F21_FFFF, "R2 readback", v, 32'h0F21FFFF);
      wr_setup(32'h0);

      // R9 power off
      nstarts = 0; ncclk = 0;
      wr_setup(launch_f(1) | 32'h0F);
      repeat (200) @(posedge clk); #1;
      chk(nstarts == 0, "R9 no start unpowered", nstarts, 0);
      chk(ncclk == 0, "R9 no cclk unpowered", ncclk, 0);
      chk(bus_rdata[31] == 1'b0, "R9 no done unpowered", bus_rdata, 0);

      // R6 launch code 0
      wr_setup(PWR | 32'h01);
      repeat (150) @(posedge clk);
      chk(nstarts == 0, "R6 code 0 starts nothing", nstarts, 0);

      // R4 divider
      wr_setup(PWR | div_f(2));
      @(negedge clk); ncclk = 0;
      repeat (60) @(negedge clk);
      chk(ncclk == 20, "R4 cclk rate div 2", ncclk, 20);

      // R3 R5 R6 R10 random single conversions
      for (int it = 0; it < 8; it++) begin
         m  = (it == 0) ? 8'h00 : 8'($urandom);
         dv = (it == 1) ? 0 : int'($urandom % 3);
         for (int i = 0; i < 8; i++) analog[i] = 12'($urandom);
         ch = low_chan((m == 0) ? 8'h01 : m);
         wr_setup(PWR | launch_f(1) | div_f(dv) | 32'(m));
         wait_done(n);
         chk(n == 65 * (dv + 1), "R5 latency", n, 65 * (dv + 1));
         rd_reg(1'b1, v);
         chk(v == exp_word(1, 0, ch, analog[ch]), "R3 R5 result word", v, exp_word(1, 0, ch, analog[ch]));
         #1;
         chk(bus_rdata[31] == 1'b0, "R10 read clears done", bus_rdata, 0);
      end

      // R10 restart on write during conversion
      wr_setup(PWR | launch_f(1) | div_f(1) | 32'h40);
      repeat (40) @(posedge clk);
      wr_setup(PWR | launch_f(0) | div_f(1) | 32'h40);
      wait_done(n);
      chk(n == 130, "R10 restart latency", n, 130);
      wr_setup(PWR);
      #1;
      chk(bus_rdata[31] == 1'b0, "R10 setup write clears done", bus_rdata, 0);

      // R7 external trigger
      wr_setup(PWR | launch_f(3) | 32'h0800_0000 | 32'h08);
      nstarts = 0;
      @(negedge clk); ext_trig[1] = 1'b1;
      wait_done(n);
      chk(n < 80 && nstarts == 1, "R7 rising trigger", n, 70);
      rd_reg(1'b1, v);
      chk(v == exp_word(1, 0, 3, analog[3]), "R7 trigger result", v, exp_word(1, 0, 3, analog[3]));
      @(negedge clk); ext_trig[1] = 1'b0;
      repeat (100) @(posedge clk);
      chk(nstarts == 1, "R7 falling ignored", nstarts, 1);
      @(negedge clk); ext_trig[0] = 1'b1;
      repeat (10) @(negedge clk); ext_trig[0] = 1'b0;
      repeat (100) @(posedge clk);
      chk(nstarts == 1, "R7 other line ignored", nstarts, 1);
      wr_setup(PWR | launch_f(3) | 32'h08);
      @(negedge clk); ext_trig[1] = 1'b1;
      repeat (20) @(posedge clk);
      chk(nstarts == 1, "R7 rising ignored on falling polarity", nstarts, 1);
      @(negedge clk); ext_trig[1] = 1'b0;
      repeat (10) @(posedge clk);
      chk(nstarts == 2, "R7 falling trigger", nstarts, 2);
      @(negedge clk); ext_trig[1] = 1'b1;
      repeat (5) @(negedge clk); ext_trig[1] = 1'b0;
      wait_done(n);
      repeat (100) @(posedge clk);
      chk(nstarts == 2, "R7 edge while busy ignored", nstarts, 2);

      // R8 R11 scan with collision
      for (int i = 0; i < 8; i++) analog[i] = 12'(100 * i + 7);
      wr_setup(PWR);
      nlog = 0;
      wr_setup(PWR | SCAN | 32'hA4);
      repeat (129) @(posedge clk);
      @(negedge clk); bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk); bus_rd = 1'b0; #1;
      chk(bus_rdata == exp_word(1, 0, 5, analog[5]), "R11 read and completion together", bus_rdata, exp_word(1, 0, 5, analog[5]));
      repeat (65) @(posedge clk); #1;
      chk(bus_rdata == exp_word(1, 1, 7, analog[7]), "R11 overrun set", bus_rdata, exp_word(1, 1, 7, analog[7]));
      rd_reg(1'b1, v);
      #1;
      chk(bus_rdata[31] == 1'b0 && bus_rdata[27] == 1'b0, "R11 read clears overrun", bus_rdata, 0);
      repeat (120) @(posedge clk);
      chk(nlog >= 5 && chan_log[0] == 2 && chan_log[1] == 5 && chan_log[2] == 7 &&
          chan_log[3] == 2 && chan_log[4] == 5, "R8 scan order", 32'(chan_log[3]), 2);
      nstarts = 0;
      wr_setup(PWR | 32'hA4);
      repeat (300) @(posedge clk);
      chk(nstarts == 1, "R8 scan stops", nstarts, 1);

      summary();
   end
endmodule